// File: doc/BRIEF.md
# Dual Mode-Selectable Timer/Counter Unit

This block holds two timer/counter channels reached through an 8-bit special-function-register (SFR) bus. A shared mode register picks each channel's count width and behaviour: a 13-bit count, a 16-bit count, an 8-bit count that reloads itself, or, on channel 0 only, a split into two independent 8-bit counters. A channel counts either machine-cycle enable pulses (`tick`) or falling edges of its own external input. It can also be told to count only the edges of that input. An overflow raises a flag that drives an interrupt line. The flag is cleared by software or by an acknowledge pulse.

Software selects the modes first. It then loads the count registers and sets the run bits in the control register. It either polls the flags through the control register or takes them from `tf_out`. An SFR read is registered: the data shows up with `sfr_rvalid` on the cycle after the request.

Top module: `dual_tmr_unit`

## Requirements
- R1: Register addresses are: control 0x88, mode 0x89, ch0 low 0x8A, ch1 low 0x8B, ch0 high 0x8C, ch1 high 0x8D. After reset, all of them read 0x00. A read is requested with `sfr_rd`, and `sfr_rdata` is valid with `sfr_rvalid` one cycle later. An unmapped address reads 0x00.
- R2: Mode register layout: bits 7:4 control channel 1 and bits 3:0 control channel 0. Within each nibble, bit 3 is the gate enable, bit 2 is the count-source select, and bits 1:0 are the mode (00 = 13-bit, 01 = 16-bit, 10 = reload, 11 = split/halt).
- R3: In mode 00, the count is {high[7:0], low[4:0]}. Low bits 7:5 read as 0. An increment from 0x1FFF wraps to 0 and sets the channel's flag.
- R4: In mode 01, {high, low} counts as 16 bits. An increment from 0xFFFF wraps to 0 and sets the flag.
- R5: In mode 10, only the low register counts. When it increments from 0xFF, it loads the high register's value and the flag is set. The high register does not change.
- R6: When channel 1 is in mode 11, both of its count registers hold their values.
- R7: When channel 0 is in mode 11, ch0 low counts under channel 0's run bit and source and sets flag 0. Ch0 high counts `tick` pulses whenever channel 1's run bit is set, and it sets flag 1. Channel 1's own overflow then does not set flag 1.
- R8: With source select 0 and gate 0, a channel adds one on each `tick` pulse while its run bit is set. With the run bit clear, it holds.
- R9: With source select 1 or gate 1, a running channel adds one per falling edge of its `ext_in` bit, detected after a two-flop synchronizer, and ignores `tick`.
- R10: Control register layout: bit 7 is flag 1, bit 6 is run 1, bit 5 is flag 0, bit 4 is run 0, and bits 3:0 read 0. A control write sets flags and run bits to the written values and overrides an overflow in the same cycle. An overflow overrides `irq_ack` in the same cycle.
- R11: A write to a count register beats an increment in the same cycle. The written value is kept and that increment is dropped.
- R12: `mode_illegal` is 1 exactly when channel 0 is in mode 10 and channel 1 is in mode 00 or 01. It is updated one cycle after the mode register changes.
- R13: `tf_out[i]` follows flag i. `irq_ack[i]` clears flag i one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rd | input | 1 | SFR read request |
| sfr_rdata | output | 8 | Registered read data |
| sfr_rvalid | output | 1 | Read data valid |
| tick | input | 1 | Machine-cycle enable pulse |
| ext_in | input | 2 | External count inputs, one per channel |
| irq_ack | input | 2 | Flag clear pulses, one per channel |
| tf_out | output | 2 | Overflow flags |
| mode_illegal | output | 1 | Illegal mode-combination status |

## Verification
A wrong count state shows up at the ports in two ways. It appears as a wrong count value on the next read, and as a flag that rises on the wrong increment or never rises, visible on `tf_out` one cycle after the overflowing increment. The bench loads values just below each wrap point and checks the value that follows, so a carry or reload error surfaces within a few `tick` pulses. Routing faults in split mode show up as flag 1 coming from the wrong counter. Synchronizer or edge faults show up as a count that differs from the number of falling edges driven.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW = 8;
  localparam logic [7:0] A_CTRL = 8'h88;
  localparam logic [7:0] A_MODE = 8'h89;
  localparam logic [7:0] A_LO0  = 8'h8A;
  localparam logic [7:0] A_LO1  = 8'h8B;
  localparam logic [7:0] A_HI0  = 8'h8C;
  localparam logic [7:0] A_HI1  = 8'h8D;

  typedef enum logic [1:0] {
    MODE13     = 2'b00,
    MODE16     = 2'b01,
    MODE_RELOAD = 2'b10,
    MODE_SPLIT = 2'b11
  } tmode_e;
endpackage

// File: rtl/tmr_fall_detect.sv
module tmr_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];

  // R9: an edge yields a single count event
  assert_single_event_R9: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W        = DW,
  parameter int LOW_BITS = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  tmode_e       mode,
  input  logic         inc,
  input  logic         inc_hi,
  input  logic         tl_we,
  input  logic         th_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] tl_q,
  output logic [W-1:0] th_q,
  output logic         ovf,
  output logic         ovf_hi
);
  localparam int NW = W + LOW_BITS;

  logic [W-1:0] tl_n, th_n;
  logic [NW:0]  s_nar;
  logic [2*W:0] s_wide;

  always_comb begin
    tl_n   = tl_q;
    th_n   = th_q;
    ovf    = 1'b0;
    ovf_hi = 1'b0;
    s_nar  = {1'b0, th_q, tl_q[LOW_BITS-1:0]} + (NW+1)'(1);
    s_wide = {1'b0, th_q, tl_q} + (2*W+1)'(1);
    if (inc) begin
      case (mode)
        MODE13: begin
          tl_n = W'(s_nar[LOW_BITS-1:0]);
          th_n = s_nar[NW-1:LOW_BITS];
          ovf  = s_nar[NW];
        end
        MODE16: begin
          tl_n = s_wide[W-1:0];
          th_n = s_wide[2*W-1:W];
          ovf  = s_wide[2*W];
        end
        MODE_RELOAD: begin
          if (&tl_q) begin
            tl_n = th_q;
            ovf  = 1'b1;
          end else begin
            tl_n = tl_q + 1'b1;
          end
        end
        default: begin
          tl_n = tl_q + 1'b1;
          ovf  = &tl_q;
        end
      endcase
    end
    if (mode == MODE_SPLIT && inc_hi) begin
      th_n   = th_q + 1'b1;
      ovf_hi = &th_q;
    end
    if (tl_we) tl_n = wdata;
    if (th_we) begin
      th_n   = wdata;
      ovf_hi = 1'b0;
    end
    if (tl_we || th_we) ovf = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tl_q <= '0;
      th_q <= '0;
    end else begin
      tl_q <= tl_n;
      th_q <= th_n;
    end
  end

  // R5: reload mode never disturbs the high register
  assert_reload_hi_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RELOAD && !th_we) |=> $stable(th_q));
  // R3: counting in 13-bit mode leaves low bits 7:5 at zero
  assert_nar_top_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE13 && inc && !tl_we) |=> (tl_q[W-1:LOW_BITS] == '0));
endmodule

// File: rtl/dual_tmr_unit.sv
module dual_tmr_unit
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NCH         = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_wdata,
  input  logic       sfr_rd,
  output logic [7:0] sfr_rdata,
  output logic       sfr_rvalid,
  input  logic       tick,
  input  logic [1:0] ext_in,
  input  logic [1:0] irq_ack,
  output logic [1:0] tf_out,
  output logic       mode_illegal
);
  logic [7:0]     tmod_q;
  logic [NCH-1:0] tr_q, tf_q, tf_set, fall, inc, tl_we, th_we, ovf, ovf_hi;
  logic [DW-1:0]  tl_q [NCH];
  logic [DW-1:0]  th_q [NCH];
  tmode_e         mode [NCH];
  logic           ctrl_we;

  assign ctrl_we  = sfr_wr && sfr_addr == A_CTRL;
  assign tl_we[0] = sfr_wr && sfr_addr == A_LO0;
  assign tl_we[1] = sfr_wr && sfr_addr == A_LO1;
  assign th_we[0] = sfr_wr && sfr_addr == A_HI0;
  assign th_we[1] = sfr_wr && sfr_addr == A_HI1;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic gate, src_ext, evt;
    assign mode[i]  = tmode_e'(tmod_q[4*i +: 2]);
    assign gate     = tmod_q[4*i + 3];
    assign src_ext  = tmod_q[4*i + 2];
    assign evt      = (gate | src_ext) ? fall[i] : tick;
    if (i == 1) begin : g_halt
      assign inc[i] = tr_q[i] & evt & (mode[i] != MODE_SPLIT);
    end else begin : g_run
      assign inc[i] = tr_q[i] & evt;
    end

    tmr_fall_detect #(.STAGES(SYNC_STAGES)) u_fd (
      .clk(clk), .rst(rst), .din(ext_in[i]), .fall(fall[i]));

    tmr_channel #(.W(DW), .LOW_BITS(5)) u_ch (
      .clk(clk), .rst(rst), .mode(mode[i]), .inc(inc[i]),
      .inc_hi((i == 0) ? (tr_q[1] & tick) : 1'b0),
      .tl_we(tl_we[i]), .th_we(th_we[i]), .wdata(sfr_wdata),
      .tl_q(tl_q[i]), .th_q(th_q[i]), .ovf(ovf[i]), .ovf_hi(ovf_hi[i]));
  end

  assign tf_set[0] = ovf[0];
  assign tf_set[1] = (mode[0] == MODE_SPLIT) ? ovf_hi[0] : (ovf[1] | ovf_hi[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmod_q       <= '0;
      tr_q         <= '0;
      tf_q         <= '0;
      mode_illegal <= 1'b0;
    end else begin
      if (sfr_wr && sfr_addr == A_MODE) tmod_q <= sfr_wdata;
      if (ctrl_we) begin
        tr_q <= {sfr_wdata[6], sfr_wdata[4]};
        tf_q <= {sfr_wdata[7], sfr_wdata[5]};
      end else begin
        tf_q <= tf_set | (tf_q & ~irq_ack);
      end
      mode_illegal <= (mode[0] == MODE_RELOAD) &&
                      (mode[1] == MODE13 || mode[1] == MODE16);
    end
  end

  assign tf_out = tf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sfr_rdata  <= '0;
      sfr_rvalid <= 1'b0;
    end else begin
      sfr_rvalid <= sfr_rd;
      if (sfr_rd) begin
        case (sfr_addr)
          A_CTRL:  sfr_rdata <= {tf_q[1], tr_q[1], tf_q[0], tr_q[0], 4'b0};
          A_MODE:  sfr_rdata <= tmod_q;
          A_LO0:   sfr_rdata <= (mode[0] == MODE13) ? {3'b0, tl_q[0][4:0]} : tl_q[0];
          A_LO1:   sfr_rdata <= (mode[1] == MODE13) ? {3'b0, tl_q[1][4:0]} : tl_q[1];
          A_HI0:   sfr_rdata <= th_q[0];
          A_HI1:   sfr_rdata <= th_q[1];
          default: sfr_rdata <= '0;
        endcase
      end
    end
  end

  // R6: channel 1 in mode 11 keeps its count
  assert_ch1_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (mode[1] == MODE_SPLIT && !tl_we[1] && !th_we[1])
      |=> ($stable(tl_q[1]) && $stable(th_q[1])));
  // R8: a stopped channel 0 outside split mode does not move
  assert_stopped_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!tr_q[0] && mode[0] != MODE_SPLIT && !tl_we[0] && !th_we[0])
      |=> ($stable(tl_q[0]) && $stable(th_q[0])));
  // R10: an overflow is never lost to an acknowledge
  assert_tf_set_R10: assert property (@(posedge clk) disable iff (rst)
    (tf_set[0] && !ctrl_we) |=> tf_q[0]);
  // R1: read data valid follows a request by one cycle
  assert_rvalid_R1: assert property (@(posedge clk) disable iff (rst)
    sfr_rd |=> sfr_rvalid);
endmodule

// File: tb/dual_tmr_unit_tb.sv
module dual_tmr_unit_tb;
  logic       clk = 0, rst = 1;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0, sfr_rdata;
  logic       sfr_wr = 0, sfr_rd = 0, sfr_rvalid, tick = 0, mode_illegal;
  logic [1:0] ext_in = 2'b11, irq_ack = 0, tf_out;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  dual_tmr_unit u_dut (.clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rd(sfr_rd), .sfr_rdata(sfr_rdata),
    .sfr_rvalid(sfr_rvalid), .tick(tick), .ext_in(ext_in), .irq_ack(irq_ack),
    .tf_out(tf_out), .mode_illegal(mode_illegal));

  // monitor: pops expected read results
  always @(negedge clk) begin
    if (!rst && sfr_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected read data %h expected none", "R1", sfr_rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (sfr_rdata !== e) begin
          fails++;
          $display("FAIL %s: read got %h expected %h", t, sfr_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sfr_wr = 1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk); sfr_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); sfr_rd = 1; sfr_addr = a;
    @(negedge clk); sfr_rd = 0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic chk(input logic [7:0] got, input logic [7:0] e, input string t);
    checks++;
    if (got !== e) begin
      fails++;
      $display("FAIL %s: got %h expected %h", t, got, e);
    end
  endtask

  task automatic edges(input int ch, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ext_in[ch] = 0;
      repeat (4) @(negedge clk);
      ext_in[ch] = 1;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state and map
    rd(8'h88, 8'h00, "R1"); rd(8'h89, 8'h00, "R1"); rd(8'h8A, 8'h00, "R1");
    rd(8'h8B, 8'h00, "R1"); rd(8'h8C, 8'h00, "R1"); rd(8'h8D, 8'h00, "R1");
    rd(8'h90, 8'h00, "R1");
    chk({6'b0, tf_out}, 8'h00, "R13");
    chk({7'b0, mode_illegal}, 8'h00, "R12");
    // R4 16-bit wrap, R10 control layout, R13 flag output and ack
    wr(8'h89, 8'h11); rd(8'h89, 8'h11, "R2");
    wr(8'h8A, 8'hFE); wr(8'h8C, 8'hFF); wr(8'h88, 8'h10);
    ticks(2);
    rd(8'h8A, 8'h00, "R4"); rd(8'h8C, 8'h00, "R4");
    chk({6'b0, tf_out}, 8'h01, "R13");
    rd(8'h88, 8'h30, "R10");
    @(negedge clk); irq_ack = 2'b01; @(negedge clk); irq_ack = 0;
    chk({6'b0, tf_out}, 8'h00, "R13");
    // R3 13-bit mode
    wr(8'h89, 8'h10);
    wr(8'h8A, 8'hFF); rd(8'h8A, 8'h1F, "R3");
    wr(8'h8C, 8'hFF); ticks(1);
    rd(8'h8A, 8'h00, "R3"); rd(8'h8C, 8'h00, "R3");
    chk({6'b0, tf_out}, 8'h01, "R3");
    wr(8'h88, 8'h10);
    wr(8'h8A, 8'h1F); wr(8'h8C, 8'h05); ticks(1);
    rd(8'h8A, 8'h00, "R3"); rd(8'h8C, 8'h06, "R3");
    // R12 illegal combination
    wr(8'h89, 8'h12); @(negedge clk);
    chk({7'b0, mode_illegal}, 8'h01, "R12");
    wr(8'h89, 8'h22); @(negedge clk);
    chk({7'b0, mode_illegal}, 8'h00, "R12");
    // R5 reload
    wr(8'h8C, 8'h80); wr(8'h8A, 8'hFE); ticks(3);
    rd(8'h8A, 8'h81, "R5"); rd(8'h8C, 8'h80, "R5");
    chk({6'b0, tf_out}, 8'h01, "R5");
    // R6 channel 1 halted
    wr(8'h89, 8'h30); wr(8'h88, 8'h40); wr(8'h8B, 8'h05); ticks(4);
    rd(8'h8B, 8'h05, "R6");
    // R7 split
    wr(8'h89, 8'h13);
    wr(8'h8A, 8'hFF); wr(8'h8C, 8'hFE); wr(8'h8B, 8'h00); wr(8'h8D, 8'h00);
    wr(8'h88, 8'h50); ticks(2);
    rd(8'h8A, 8'h01, "R7"); rd(8'h8C, 8'h00, "R7"); rd(8'h8B, 8'h02, "R7");
    rd(8'h88, 8'hF0, "R7");
    wr(8'h88, 8'h50); wr(8'h8B, 8'hFF); wr(8'h8D, 8'hFF); ticks(1);
    rd(8'h8B, 8'h00, "R7"); rd(8'h8C, 8'h01, "R7"); rd(8'h88, 8'h50, "R7");
    // R8 stopped
    wr(8'h88, 8'h00); wr(8'h89, 8'h11); wr(8'h8A, 8'h03); ticks(3);
    rd(8'h8A, 8'h03, "R8");
    // R9 external edges, source select then gate
    wr(8'h89, 8'h05); wr(8'h8A, 8'h00); wr(8'h8C, 8'h00); wr(8'h88, 8'h10);
    ticks(3); rd(8'h8A, 8'h00, "R9");
    edges(0, 3); rd(8'h8A, 8'h03, "R9");
    wr(8'h89, 8'h91); wr(8'h8B, 8'h00); wr(8'h8D, 8'h00); wr(8'h88, 8'h40);
    ticks(2); edges(1, 2); rd(8'h8B, 8'h02, "R9");
    // R11 write beats increment
    wr(8'h89, 8'h01); wr(8'h88, 8'h10);
    @(negedge clk); tick = 1; sfr_wr = 1; sfr_addr = 8'h8A; sfr_wdata = 8'h40;
    @(negedge clk); tick = 0; sfr_wr = 0;
    rd(8'h8A, 8'h40, "R11");
    // R10 overflow beats ack
    wr(8'h8A, 8'hFF); wr(8'h8C, 8'hFF);
    @(negedge clk); tick = 1; irq_ack = 2'b01;
    @(negedge clk); tick = 0; irq_ack = 0;
    chk({6'b0, tf_out}, 8'h01, "R10");
    // R10 control write beats overflow
    wr(8'h8A, 8'hFF); wr(8'h8C, 8'hFF);
    @(negedge clk); tick = 1; sfr_wr = 1; sfr_addr = 8'h88; sfr_wdata = 8'h10;
    @(negedge clk); tick = 0; sfr_wr = 0;
    chk({6'b0, tf_out}, 8'h00, "R10");
    repeat (3) @(negedge clk);
    chk(8'(exp_q.size()), 8'h00, "R1");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule